// File: doc/BRIEF.md
# Dual-Timing Synchronous FIFO Core

This block is a single-clock FIFO controller around an inferred RAM whose depth is a power of two set by a parameter. A producer pushes words with a write enable and a consumer pulls them with a read enable. The same clock edge may carry one push and one pull. An occupancy count is brought out for a separate programmable-flag unit.

Two read-timing conventions are available, picked when the block leaves master reset. In standard timing, the consumer asks for a word and receives it on the following cycle. The status pins then mean "empty" and "full". In fall-through timing, the oldest word moves onto the output by itself. The status pins then mean "output holds a valid word" and "room for another write".

A retransmit pulse rewinds reading to the first word written since the last reset, with no dead cycles. There are two reset levels. Master reset clears everything and latches the timing mode. Partial reset discards the stored data and keeps the latched mode.

Top module: `fifo_dualmode`

## Requirements
- R1: While `mstRstN` is low at a clock edge, the FIFO is cleared after that edge. `fillLevel` reads 0 and `rdData` reads 0. In standard mode `rdStatus`=1 and `wrStatus`=0. In fall-through mode `rdStatus`=0 and `wrStatus`=1.
- R2: In standard mode, a read enable sampled while `fillLevel`>0 puts the oldest word on `rdData` after that edge. The word stays there until the next accepted read.
- R3: In fall-through mode, a word written into an empty FIFO appears on `rdData` without any read enable, two edges after the write edge. `rdStatus` rises to 1 at the same time. A read enable while `rdStatus`=1 consumes the displayed word.
- R4: When `fillLevel` equals the depth, the FIFO is full: `wrStatus`=1 in standard mode and `wrStatus`=0 in fall-through mode. A write while full is dropped and the stored data is unchanged.
- R5: A read while the FIFO is empty is ignored. `fillLevel` and `rdData` are unchanged.
- R6: A write and a read accepted at the same edge leave `fillLevel` unchanged. The read returns the oldest word.
- R7: In standard mode, a `rtEn` pulse sets `fillLevel` to the number of words written since the last reset, provided no more than the depth were written. A read in the next cycle returns the first of those words. Read and write enables are ignored in the retransmit cycle.
- R8: In fall-through mode, after a `rtEn` edge the first word written since reset is on `rdData`, `rdStatus`=1 and `fillLevel` equals the number of words written.
- R9: A low `prtRstN` empties the FIFO: `fillLevel`=0. The timing mode latched at master reset is kept.
- R10: `fwftSel` is sampled only while `mstRstN` is low. Changing it at other times has no effect.
- R11: `fillLevel` counts words written and not yet consumed by the reader. In fall-through mode this includes the word shown on `rdData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| mstRstN | input | 1 | Synchronous master reset, active low; latches `fwftSel` |
| prtRstN | input | 1 | Synchronous partial reset, active low; keeps the mode |
| fwftSel | input | 1 | Timing mode at master reset: 0 standard, 1 fall-through |
| wrEn | input | 1 | Write enable |
| wrData | input | DATA_W | Word to write |
| rdEn | input | 1 | Read enable |
| rtEn | input | 1 | Retransmit pulse |
| rdData | output | DATA_W | Registered output word |
| rdStatus | output | 1 | Standard: empty; fall-through: output ready |
| wrStatus | output | 1 | Standard: full; fall-through: input ready |
| fillLevel | output | ADDR_W+1 | Occupancy count |

## Verification
In standard mode a read word is due on `rdData` one edge after the read edge. In fall-through mode a word written into an empty FIFO is due two edges after its write. A retransmit restores `fillLevel` after one edge; in fall-through mode it also restores `rdData` after that edge.

The bench drives every input at the falling edge and reads status one nanosecond after the rising edge that should update it. A scoreboard queue holds the written words in order. For standard reads, the monitor compares at the falling edge that follows the read edge. For fall-through reads, it compares the displayed word before the consuming edge.

// File: rtl/fifo_dm_pkg.sv
package fifo_dm_pkg;
  // strobes from control to datapath, one cycle's worth
  typedef struct packed {
    logic push;        // store wrData at the write pointer
    logic pop;         // load rdData from the read pointer and advance it
    logic rewind;      // move the read pointer back to address 0
    logic rewindLoad;  // with rewind: also show address 0 at once
    logic clear;       // zero the pointers and the output word
  } fifoStrobes_t;
endpackage

// File: rtl/fifo_dm_datapath.sv
module fifo_dm_datapath
  import fifo_dm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  fifoStrobes_t      stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wrPtr;
  logic [ADDR_W-1:0] rdPtr;

  always_ff @(posedge clk) begin
    if (stb.push && !stb.clear) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (stb.clear) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      rdData <= '0;
    end else begin
      if (stb.push) wrPtr <= wrPtr + 1'b1;
      if (stb.rewind) begin
        if (stb.rewindLoad) begin
          rdData <= mem[0];
          rdPtr  <= ADDR_W'(1);
        end else begin
          rdPtr  <= '0;
        end
      end else if (stb.pop) begin
        rdData <= mem[rdPtr];
        rdPtr  <= rdPtr + 1'b1;
      end
    end
  end

  // R7
  nopush_on_rewind_chk: assert property (@(posedge clk) disable iff (stb.clear)
    stb.rewind |-> !stb.push && !stb.pop);
endmodule

// File: rtl/fifo_dm_ctrl.sv
module fifo_dm_ctrl
  import fifo_dm_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              mstRstN,
  input  logic              prtRstN,
  input  logic              fwftSel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              rtEn,
  output fifoStrobes_t      stb,
  output logic              rdStatus,
  output logic              wrStatus,
  output logic [ADDR_W:0]   fillLevel
);
  localparam int CW = ADDR_W + 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(1 << ADDR_W);

  logic          modeFwft;
  logic [CW-1:0] occ;       // words owned by the reader side
  logic [CW-1:0] memCnt;    // words still in the RAM
  logic [CW-1:0] wrTotal;   // writes since reset, saturating
  logic          outValid;  // fall-through output register holds a word

  logic rstAny, isFull, wrAcc, rdAcc, popMem, rtLoad;

  always_comb begin
    rstAny = !mstRstN || !prtRstN;
    isFull = (occ == DEPTH_C);
    wrAcc  = wrEn && !isFull && !rtEn;
    if (modeFwft) begin
      rdAcc  = rdEn && outValid && !rtEn;
      popMem = (memCnt != '0) && (!outValid || rdAcc) && !rtEn;
    end else begin
      rdAcc  = rdEn && (occ != '0) && !rtEn;
      popMem = rdAcc;
    end
    rtLoad = modeFwft && (wrTotal != '0);
    stb.push       = wrAcc;
    stb.pop        = popMem;
    stb.rewind     = rtEn;
    stb.rewindLoad = rtLoad;
    stb.clear      = rstAny;
  end

  always_ff @(posedge clk) begin
    if (!mstRstN) modeFwft <= fwftSel;
  end

  always_ff @(posedge clk) begin
    if (rstAny) begin
      occ      <= '0;
      memCnt   <= '0;
      wrTotal  <= '0;
      outValid <= 1'b0;
    end else if (rtEn) begin
      occ <= wrTotal;
      if (rtLoad) begin
        memCnt   <= wrTotal - CW'(1);
        outValid <= 1'b1;
      end else begin
        memCnt   <= modeFwft ? '0 : wrTotal;
        outValid <= 1'b0;
      end
    end else begin
      occ    <= occ + CW'(wrAcc) - CW'(rdAcc);
      memCnt <= memCnt + CW'(wrAcc) - CW'(popMem);
      if (modeFwft && popMem) outValid <= 1'b1;
      else if (rdAcc)         outValid <= 1'b0;
      if (wrAcc && wrTotal != DEPTH_C) wrTotal <= wrTotal + CW'(1);
    end
  end

  assign rdStatus  = modeFwft ? outValid : (occ == '0);
  assign wrStatus  = modeFwft ? !isFull : isFull;
  assign fillLevel = occ;

  // R4
  occ_bound_chk: assert property (@(posedge clk) disable iff (rstAny)
    occ <= DEPTH_C);
  // R11
  fwft_occ_chk: assert property (@(posedge clk) disable iff (rstAny)
    modeFwft |-> occ == memCnt + CW'(outValid));
  // R5
  empty_read_chk: assert property (@(posedge clk) disable iff (rstAny)
    (!modeFwft && occ == '0 && rdEn && !wrEn && !rtEn) |=> occ == '0);
  // R7
  rewind_level_chk: assert property (@(posedge clk) disable iff (rstAny)
    rtEn |=> occ == $past(wrTotal));
  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!mstRstN)
    mstRstN |=> $stable(modeFwft));
endmodule

// File: rtl/fifo_dualmode.sv
module fifo_dualmode
  import fifo_dm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              mstRstN,
  input  logic              prtRstN,
  input  logic              fwftSel,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic              rtEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdStatus,
  output logic              wrStatus,
  output logic [ADDR_W:0]   fillLevel
);
  fifoStrobes_t stb;

  fifo_dm_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .mstRstN(mstRstN), .prtRstN(prtRstN), .fwftSel(fwftSel),
    .wrEn(wrEn), .rdEn(rdEn), .rtEn(rtEn), .stb(stb),
    .rdStatus(rdStatus), .wrStatus(wrStatus), .fillLevel(fillLevel)
  );

  fifo_dm_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .stb(stb), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: tb/sim_fifo_dualmode.sv
`timescale 1ns/1ps
module sim_fifo_dualmode;
  localparam int DW = 16;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic mstRstN = 1'b0, prtRstN = 1'b1, fwftSel = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0, rtEn = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic rdStatus, wrStatus;
  logic [AW:0] fillLevel;

  int nChecks = 0, nFails = 0;
  int reqCnt = 0, doneCnt = 0;
  string reqTag = "";
  logic [DW-1:0] expQ [$];

  always #2.5 clk = ~clk;  // 200 MHz

  fifo_dualmode #(.DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk(clk), .mstRstN(mstRstN), .prtRstN(prtRstN), .fwftSel(fwftSel),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rtEn(rtEn),
    .rdData(rdData), .rdStatus(rdStatus), .wrStatus(wrStatus),
    .fillLevel(fillLevel)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: compares rdData to the oldest expected word on request
  always @(negedge clk) begin
    if (reqCnt != doneCnt) begin
      doneCnt++;
      if (expQ.size() == 0) chk(reqTag, "scoreboard underrun", 1, 0);
      else chk(reqTag, "rdData", int'(rdData), int'(expQ.pop_front()));
    end
  end

  task automatic step(input bit w, input logic [DW-1:0] d, input bit r, input bit rt);
    @(negedge clk);
    wrEn = w; wrData = d; rdEn = r; rtEn = rt;
    @(posedge clk); #1;
    wrEn = 0; rdEn = 0; rtEn = 0;
  endtask

  task automatic push(input logic [DW-1:0] d);
    expQ.push_back(d);
    step(1, d, 0, 0);
  endtask

  task automatic stdRead(input string tag);
    step(0, '0, 1, 0);
    reqTag = tag; reqCnt++;
  endtask

  task automatic fwftRead(input string tag);
    chk(tag, "rdStatus before read", int'(rdStatus), 1);
    reqTag = tag; reqCnt++;
    step(0, '0, 1, 0);
  endtask

  task automatic masterReset(input bit sel);
    @(negedge clk); mstRstN = 0; fwftSel = sel;
    @(posedge clk); @(posedge clk);
    @(negedge clk); mstRstN = 1;
    @(posedge clk); #1;
    expQ.delete();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    chk("WDOG", "timeout", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    // standard mode
    masterReset(0);
    chk("R1", "std rdStatus", int'(rdStatus), 1);
    chk("R1", "std wrStatus", int'(wrStatus), 0);
    chk("R1", "fillLevel", int'(fillLevel), 0);
    chk("R1", "rdData", int'(rdData), 0);

    step(0, '0, 1, 0);
    chk("R5", "fillLevel after empty read", int'(fillLevel), 0);
    chk("R5", "rdData after empty read", int'(rdData), 0);

    push(16'hA000); push(16'hA001); push(16'hA002);
    chk("R11", "fillLevel after 3 writes", int'(fillLevel), 3);
    stdRead("R2"); stdRead("R2");

    expQ.push_back(16'hA003);
    step(1, 16'hA003, 1, 0);
    reqTag = "R6"; reqCnt++;
    chk("R6", "fillLevel after write+read", int'(fillLevel), 1);

    for (int i = 4; i < 11; i++) push(DW'(16'hA000 + i));
    chk("R4", "std full flag", int'(wrStatus), 1);
    chk("R11", "fillLevel at full", int'(fillLevel), DEPTH);
    step(1, 16'hDEAD, 0, 0);
    chk("R4", "fillLevel after write when full", int'(fillLevel), DEPTH);
    for (int i = 0; i < DEPTH; i++) stdRead("R4");
    chk("R4", "empty after drain", int'(rdStatus), 1);

    // partial reset keeps standard mode
    @(negedge clk); prtRstN = 0; @(posedge clk); @(negedge clk); prtRstN = 1;
    @(posedge clk); #1;
    expQ.delete();
    chk("R9", "fillLevel after partial reset", int'(fillLevel), 0);
    chk("R9", "std empty flag kept", int'(rdStatus), 1);

    push(16'hB000); push(16'hB001); push(16'hB002);
    stdRead("R7");
    step(0, '0, 0, 1);
    expQ.delete();
    expQ.push_back(16'hB000); expQ.push_back(16'hB001); expQ.push_back(16'hB002);
    chk("R7", "fillLevel after retransmit", int'(fillLevel), 3);
    stdRead("R7"); stdRead("R7"); stdRead("R7");

    // mode select outside master reset
    fwftSel = 1;
    push(16'hC000);
    step(0, '0, 0, 0); step(0, '0, 0, 0); step(0, '0, 0, 0);
    chk("R10", "no fall-through outside reset", int'(rdData), 16'hB002);
    chk("R10", "still std status", int'(rdStatus), 0);
    stdRead("R10");

    // fall-through mode
    masterReset(1);
    chk("R1", "fwft rdStatus", int'(rdStatus), 0);
    chk("R1", "fwft wrStatus", int'(wrStatus), 1);
    chk("R1", "fwft fillLevel", int'(fillLevel), 0);

    push(16'hD000);
    chk("R3", "not yet ready", int'(rdStatus), 0);
    step(0, '0, 0, 0);
    chk("R3", "ready without read", int'(rdStatus), 1);
    chk("R3", "first word shown", int'(rdData), 16'hD000);
    chk("R11", "fwft fillLevel counts output word", int'(fillLevel), 1);
    push(16'hD001); push(16'hD002);
    fwftRead("R3"); fwftRead("R3"); fwftRead("R3");
    chk("R3", "not ready when drained", int'(rdStatus), 0);

    for (int i = 0; i < DEPTH; i++) push(DW'(16'hF000 + i));
    chk("R4", "fwft input-ready low at full", int'(wrStatus), 0);
    step(1, 16'hBEEF, 0, 0);
    chk("R4", "fwft fillLevel after write when full", int'(fillLevel), DEPTH);
    for (int i = 0; i < DEPTH; i++) fwftRead("R4");

    masterReset(1);
    push(16'hE000); push(16'hE001); push(16'hE002); push(16'hE003);
    step(0, '0, 0, 0);
    fwftRead("R8"); fwftRead("R8");
    step(0, '0, 0, 1);
    expQ.delete();
    for (int i = 0; i < 4; i++) expQ.push_back(DW'(16'hE000 + i));
    chk("R8", "ready after retransmit", int'(rdStatus), 1);
    chk("R8", "first word after retransmit", int'(rdData), 16'hE000);
    chk("R8", "fillLevel after retransmit", int'(fillLevel), 4);
    for (int i = 0; i < 4; i++) fwftRead("R8");

    fwftSel = 0;
    push(16'h1234);
    @(negedge clk); prtRstN = 0; @(posedge clk); @(negedge clk); prtRstN = 1;
    @(posedge clk); #1;
    expQ.delete();
    chk("R9", "fwft fillLevel after partial reset", int'(fillLevel), 0);
    chk("R9", "fwft input-ready kept", int'(wrStatus), 1);
    chk("R9", "fwft not-ready kept", int'(rdStatus), 0);

    @(negedge clk);
    chk("R2", "scoreboard drained", expQ.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule